// File: doc/BRIEF.md
# Look-Ahead Pipelined Second-Order IIR Filter

This block filters a stream of signed fixed-point samples through one second-order recursive section. Its recursion is rewritten by scattered look-ahead, so the loop needs only the outputs from four and eight samples earlier. The adder and multipliers that form a new output never wait on the output just produced, which leaves room for retiming at high clock rates. A seven-tap compensating FIR placed ahead of the original three-tap numerator cancels the six extra poles, so the overall response is that of the intended biquad.

The caller supplies the two original denominator coefficients `A1` and `A2`, the numerator `B0..B2`, and a gain applied before and after the section, all as real-valued parameters. At elaboration the block derives the compensator taps and the two look-ahead feedback coefficients from them. It then quantizes every coefficient to `COEF_W` bits with `CFRAC` fraction bits. Samples enter with `in_valid`. Each result leaves a fixed number of cycles later with `out_valid`. Every cast of an accumulator or of the output uses one rounding mode and one overflow policy, both chosen by parameter.

Top module: `lapb_biquad`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0, and samples still in the pipeline are discarded.
- R2: `out_valid` is `in_valid` delayed by exactly 5 clock cycles (localparam `LATENCY`).
- R3: The impulse response matches bit for bit a model built from five stages, each cast with the selected policy: pre-gain, then the compensator P(z) = (1 - A1 z^-1 + A2 z^-2)(1 - e1 z^-2 + e2 z^-4), then the numerator B(z), then the recursion y = w - c4*y[n-4] - c8*y[n-8], then post-gain. Here e1 = 2*A2 - A1^2, e2 = A2^2, c4 = 2*e2 - e1^2 and c8 = e2^2. There is no feedback term at delay 1 or 2.
- R4: The response to a large constant input also matches the model bit for bit, including results that overflow the output width.
- R5: Gaps in `in_valid` do not alter the response. The output sequence depends only on the sequence of valid samples.
- R6: When `in_valid` is 0, `in_data` is ignored. It produces no output and changes no filter state.
- R7: With the default policy, every cast rounds toward minus infinity (floor) and overflow wraps in two's complement. A 16-bit output of +40000 therefore appears as -25536.
- R8: With the convergent policy and saturation selected, exact halves round to the even integer and results clip to [-32768, 32767] for a 16-bit output.
- R9: While `out_valid` is 0, `out_data` holds the last valid result.
- R10: Each coefficient is quantized to the nearest multiple of 2^-CFRAC and saturated to the signed `COEF_W` range. A gain of 1.0 becomes 2^CFRAC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a sample to filter |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Marks `out_data` as a filtered result |
| out_data | output | OUT_W | Signed filtered sample |

## Verification
Four properties are checked on every cycle: the fixed five-cycle valid delay, the bound on how many samples are in flight, the quiet output during reset, and the held output between results. The numeric behaviour can only be shown by the bench's scenarios, which compare every result against an independent integer model. Those scenarios cover the impulse and step responses, the two rounding and overflow policies, and sequences with gaps and with garbage on idle cycles. The derivation and quantization of the look-ahead coefficients are also visible only through those comparisons.

// File: rtl/lapb_pkg.sv
package lapb_pkg;

   typedef enum logic [2:0] {
      RM_FLOOR = 3'd0,
      RM_CEIL  = 3'd1,
      RM_CONV  = 3'd2,
      RM_NEAR  = 3'd3,
      RM_ROUND = 3'd4,
      RM_ZERO  = 3'd5
   } rmode_e;

   // Divide by 2^shift with the chosen rounding, then fit into width bits.
   function automatic longint lapb_cast(input longint v, input int shift,
                                        input int width, input rmode_e rm,
                                        input bit sat);
      longint f, rem, half, hi, lo;
      bit     up;
      f    = v >>> shift;
      rem  = v - (f <<< shift);
      half = (shift > 0) ? (longint'(1) <<< (shift - 1)) : longint'(0);
      up   = 1'b0;
      if (rem != 0) begin
         case (rm)
            RM_CEIL:  up = 1'b1;
            RM_ZERO:  up = (v < 0);
            RM_NEAR:  up = (rem >= half);
            RM_ROUND: up = (rem > half) || ((rem == half) && (v >= 0));
            RM_CONV:  up = (rem > half) || ((rem == half) && f[0]);
            default:  up = 1'b0;
         endcase
      end
      if (up) f = f + 1;
      hi = (longint'(1) <<< (width - 1)) - 1;
      lo = -hi - 1;
      if (sat) begin
         if (f > hi) f = hi;
         else if (f < lo) f = lo;
      end else begin
         f = (f <<< (64 - width)) >>> (64 - width);
      end
      return f;
   endfunction

   // Coefficient quantization: nearest step of 2^-frac, saturated to width bits.
   function automatic int lapb_coef(input real c, input int width, input int frac);
      real    s;
      longint q, hi;
      s  = c * (2.0 ** frac);
      q  = longint'($floor(s + 0.5));
      hi = (longint'(1) <<< (width - 1)) - 1;
      if (q > hi) q = hi;
      else if (q < -hi - 1) q = -hi - 1;
      return int'(q);
   endfunction

endpackage

// File: rtl/lapb_gain.sv
module lapb_gain
   import lapb_pkg::*;
#(
   parameter int     DIN_W  = 16,
   parameter int     DOUT_W = 24,
   parameter int     CFRAC  = 14,
   parameter int     GAIN   = 16384,
   parameter rmode_e RMODE  = RM_FLOOR,
   parameter bit     SAT    = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DIN_W-1:0]  in_data,
   output logic                     out_valid,
   output logic signed [DOUT_W-1:0] out_data
);

   localparam int UNITY = 1 << CFRAC;

   longint prod;

   generate
      if (GAIN == UNITY) begin : g_unity
         assign prod = longint'(in_data) <<< CFRAC;
      end else begin : g_mult
         assign prod = longint'(in_data) * longint'(GAIN);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_data <= DOUT_W'(lapb_cast(prod, CFRAC, DOUT_W, RMODE, SAT));
      end
   end

endmodule

// File: rtl/lapb_fir.sv
module lapb_fir
   import lapb_pkg::*;
#(
   parameter int                     DIN_W  = 24,
   parameter int                     DOUT_W = 24,
   parameter int                     COEF_W = 18,
   parameter int                     CFRAC  = 14,
   parameter int                     NTAP   = 3,
   parameter logic [NTAP*COEF_W-1:0] TAPS   = '0,
   parameter rmode_e                 RMODE  = RM_FLOOR,
   parameter bit                     SAT    = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DIN_W-1:0]  in_data,
   output logic                     out_valid,
   output logic signed [DOUT_W-1:0] out_data
);

   generate
      if (NTAP < 2) begin : g_bad_ntap
         $error("lapb_fir: NTAP must be at least 2");
      end
   endgenerate

   logic signed [DIN_W-1:0]  line [NTAP];
   logic signed [DIN_W-1:0]  past [1:NTAP-1];
   logic signed [COEF_W-1:0] tapv [NTAP];
   longint                   acc;

   assign line[0] = in_data;

   genvar k;
   generate
      for (k = 0; k < NTAP; k++) begin : g_tap
         assign tapv[k] = TAPS[k*COEF_W +: COEF_W];
         if (k > 0) begin : g_hist
            assign line[k] = past[k];
         end
      end
   endgenerate

   always_comb begin
      acc = 0;
      for (int i = 0; i < NTAP; i++)
         acc = acc + longint'(line[i]) * longint'(tapv[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         for (int i = 1; i < NTAP; i++) past[i] <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= DOUT_W'(lapb_cast(acc, CFRAC, DOUT_W, RMODE, SAT));
            past[1]  <= in_data;
            for (int i = 2; i < NTAP; i++) past[i] <= past[i-1];
         end
      end
   end

endmodule

// File: rtl/lapb_recur.sv
module lapb_recur
   import lapb_pkg::*;
#(
   parameter int     W      = 24,
   parameter int     CFRAC  = 14,
   parameter int     LA     = 4,
   parameter int     C_NEAR = 1024,
   parameter int     C_FAR  = 64,
   parameter rmode_e RMODE  = RM_FLOOR,
   parameter bit     SAT    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_data,
   output logic                out_valid,
   output logic signed [W-1:0] out_data
);

   localparam int FAR = 2 * LA;

   // hist[j] holds the output produced j valid samples ago
   logic signed [W-1:0] hist [1:FAR];
   longint              fb_sum, fb_q, y_next;

   always_comb begin
      fb_sum = longint'(C_NEAR) * longint'(hist[LA]);
      if (C_FAR != 0)
         fb_sum = fb_sum + longint'(C_FAR) * longint'(hist[FAR]);
      fb_q   = lapb_cast(fb_sum, CFRAC, W, RMODE, SAT);
      y_next = lapb_cast(longint'(in_data) - fb_q, 0, W, RMODE, SAT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         for (int i = 1; i <= FAR; i++) hist[i] <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= W'(y_next);
            hist[1]  <= W'(y_next);
            for (int i = 2; i <= FAR; i++) hist[i] <= hist[i-1];
         end
      end
   end

endmodule

// File: rtl/lapb_biquad.sv
module lapb_biquad
   import lapb_pkg::*;
#(
   parameter int     DATA_W    = 16,
   parameter int     OUT_W     = 16,
   parameter int     ACC_W     = 24,
   parameter int     COEF_W    = 18,
   parameter int     CFRAC     = 14,
   parameter real    A1        = -0.5,
   parameter real    A2        = 0.25,
   parameter real    B0        = 0.25,
   parameter real    B1        = 0.5,
   parameter real    B2        = 0.25,
   parameter real    PRE_GAIN  = 1.0,
   parameter real    POST_GAIN = 1.0,
   parameter rmode_e RMODE     = RM_FLOOR,
   parameter bit     SAT       = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_data
);

   localparam int LA      = 4;
   localparam int LATENCY = 5;

   // Scattered look-ahead coefficients derived from the original denominator
   localparam real E1 = 2.0 * A2 - A1 * A1;
   localparam real E2 = A2 * A2;
   localparam real C4 = 2.0 * E2 - E1 * E1;
   localparam real C8 = E2 * E2;

   localparam int QP0 = lapb_coef(1.0,          COEF_W, CFRAC);
   localparam int QP1 = lapb_coef(-A1,          COEF_W, CFRAC);
   localparam int QP2 = lapb_coef(A2 - E1,      COEF_W, CFRAC);
   localparam int QP3 = lapb_coef(A1 * E1,      COEF_W, CFRAC);
   localparam int QP4 = lapb_coef(E2 - A2 * E1, COEF_W, CFRAC);
   localparam int QP5 = lapb_coef(-A1 * E2,     COEF_W, CFRAC);
   localparam int QP6 = lapb_coef(A2 * E2,      COEF_W, CFRAC);
   localparam int QB0 = lapb_coef(B0,           COEF_W, CFRAC);
   localparam int QB1 = lapb_coef(B1,           COEF_W, CFRAC);
   localparam int QB2 = lapb_coef(B2,           COEF_W, CFRAC);
   localparam int QC4 = lapb_coef(C4,           COEF_W, CFRAC);
   localparam int QC8 = lapb_coef(C8,           COEF_W, CFRAC);
   localparam int QG1 = lapb_coef(PRE_GAIN,     COEF_W, CFRAC);
   localparam int QG2 = lapb_coef(POST_GAIN,    COEF_W, CFRAC);

   localparam logic [7*COEF_W-1:0] COMP_TAPS = {
      COEF_W'(QP6), COEF_W'(QP5), COEF_W'(QP4), COEF_W'(QP3),
      COEF_W'(QP2), COEF_W'(QP1), COEF_W'(QP0)};
   localparam logic [3*COEF_W-1:0] NUM_TAPS = {
      COEF_W'(QB2), COEF_W'(QB1), COEF_W'(QB0)};

   generate
      if (COEF_W > 24 || CFRAC >= COEF_W - 1) begin : g_bad_coef
         $error("lapb_biquad: COEF_W at most 24 with CFRAC below COEF_W-1");
      end
      if (ACC_W + COEF_W + 4 > 62) begin : g_bad_acc
         $error("lapb_biquad: ACC_W + COEF_W too wide for 64-bit sums");
      end
      if (DATA_W > ACC_W || OUT_W > ACC_W) begin : g_bad_io
         $error("lapb_biquad: DATA_W and OUT_W must not exceed ACC_W");
      end
   endgenerate

   logic                    v1, v2, v3, v4;
   logic signed [ACC_W-1:0] d1, d2, d3, d4;

   lapb_gain #(.DIN_W(DATA_W), .DOUT_W(ACC_W), .CFRAC(CFRAC), .GAIN(QG1),
               .RMODE(RMODE), .SAT(SAT)) u_pre (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(v1), .out_data(d1));

   lapb_fir #(.DIN_W(ACC_W), .DOUT_W(ACC_W), .COEF_W(COEF_W), .CFRAC(CFRAC),
              .NTAP(7), .TAPS(COMP_TAPS), .RMODE(RMODE), .SAT(SAT)) u_comp (
      .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_data(d1),
      .out_valid(v2), .out_data(d2));

   lapb_fir #(.DIN_W(ACC_W), .DOUT_W(ACC_W), .COEF_W(COEF_W), .CFRAC(CFRAC),
              .NTAP(3), .TAPS(NUM_TAPS), .RMODE(RMODE), .SAT(SAT)) u_num (
      .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_data(d2),
      .out_valid(v3), .out_data(d3));

   lapb_recur #(.W(ACC_W), .CFRAC(CFRAC), .LA(LA), .C_NEAR(QC4), .C_FAR(QC8),
                .RMODE(RMODE), .SAT(SAT)) u_loop (
      .clk(clk), .rst_n(rst_n), .in_valid(v3), .in_data(d3),
      .out_valid(v4), .out_data(d4));

   lapb_gain #(.DIN_W(ACC_W), .DOUT_W(OUT_W), .CFRAC(CFRAC), .GAIN(QG2),
               .RMODE(RMODE), .SAT(SAT)) u_post (
      .clk(clk), .rst_n(rst_n), .in_valid(v4), .in_data(d4),
      .out_valid(out_valid), .out_data(out_data));

endmodule

// File: rtl/lapb_biquad_chk.sv
module lapb_biquad_chk #(
   parameter int OUT_W   = 16,
   parameter int LATENCY = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_data
);

   logic [3:0] seen;
   int         inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= '0;
         inflight <= 0;
      end else begin
         if (seen != 4'hF) seen <= seen + 4'd1;
         inflight <= inflight + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(seen) >= LATENCY) |-> (out_valid == $past(in_valid, 5)));  // R2

   AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (inflight >= 0) && (inflight <= LATENCY));  // R2

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_data == '0));  // R1

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((seen != 4'h0) && !out_valid) |-> $stable(out_data));  // R9

endmodule

bind lapb_biquad lapb_biquad_chk #(.OUT_W(OUT_W), .LATENCY(LATENCY)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .out_valid(out_valid), .out_data(out_data));

// File: tb/lapb_biquad_test.sv
module lapb_biquad_test;
   import lapb_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               ov [2];
   logic signed [15:0] od [2];

   lapb_biquad uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(ov[0]), .out_data(od[0]));

   lapb_biquad #(.POST_GAIN(4.0), .RMODE(RM_CONV), .SAT(1'b1)) uut_sat (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(ov[1]), .out_data(od[1]));

   // Stimulus table: sample value and valid flag (invalid rows carry garbage)
   localparam int NV = 32;
   localparam int TAB_X [NV] = '{1200, -800, 31111, 4000, -29999, 12345, 7, -7,
                                 2500, -17000, -3100, 9000, -12000, 150, 22222, 0,
                                 640, -640, 20000, -20000, 1, 2, -32768, 4,
                                 -5000, 5000, 32767, -77, 0, 10000, -10000, 333};
   localparam bit TAB_V [NV] = '{1, 1, 0, 1, 0, 0, 1, 1, 1, 0, 1, 1, 1, 0, 0, 1,
                                 1, 0, 1, 1, 1, 1, 0, 1, 1, 1, 0, 1, 1, 1, 1, 0};

   // Expected integer coefficients (Q14) for the default parameter set
   localparam longint KP [7] = '{16384, 8192, 0, -2048, 0, 512, 256};
   localparam longint KB [3] = '{4096, 8192, 4096};
   localparam longint K4 = 1024;
   localparam longint K8 = 64;

   int     nchk = 0, nfail = 0, cyc = 0;
   bit     done = 1'b0;
   string  cur_req = "R1";
   longint hx [2][7];
   longint hw [2][3];
   longint hy [2][9];
   longint expq [2][1024];
   int     wr [2], rd [2];
   int     dcyc [1024];
   longint last_out [2];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input longint got, input longint exp);
      nchk++;
      if (got != exp) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic longint brnd(input longint v, input int sh, input int mode);
      real r, fl, fr, res;
      r  = real'(v) / (2.0 ** sh);
      fl = $floor(r);
      fr = r - fl;
      case (mode)
         1:       res = $ceil(r);
         2:       res = (fr > 0.5) ? fl + 1.0 : (fr < 0.5) ? fl :
                        (($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0);
         3:       res = $floor(r + 0.5);
         4:       res = (r >= 0.0) ? $floor(r + 0.5) : -$floor(-r + 0.5);
         5:       res = (r >= 0.0) ? fl : $ceil(r);
         default: res = fl;
      endcase
      return longint'(res);
   endfunction

   function automatic longint bfit(input longint v, input int w, input bit sat);
      longint m, h, t;
      m = longint'(1) << w;
      h = m / 2;
      if (sat) return (v > h - 1) ? h - 1 : (v < -h) ? -h : v;
      t = ((v % m) + m) % m;
      return (t >= h) ? t - m : t;
   endfunction

   task automatic model_step(input int id, input longint x, output longint y_out);
      int     mode;
      bit     sat;
      longint gpost, g, s, c, w, fb, y;
      mode  = (id == 1) ? 2 : 0;
      sat   = (id == 1);
      gpost = (id == 1) ? 65536 : 16384;
      g = bfit(brnd(x * 16384, 14, mode), 24, sat);
      for (int k = 6; k > 0; k--) hx[id][k] = hx[id][k-1];
      hx[id][0] = g;
      s = 0;
      for (int k = 0; k < 7; k++) s += KP[k] * hx[id][k];
      c = bfit(brnd(s, 14, mode), 24, sat);
      for (int k = 2; k > 0; k--) hw[id][k] = hw[id][k-1];
      hw[id][0] = c;
      s = 0;
      for (int k = 0; k < 3; k++) s += KB[k] * hw[id][k];
      w  = bfit(brnd(s, 14, mode), 24, sat);
      fb = bfit(brnd(K4 * hy[id][4] + K8 * hy[id][8], 14, mode), 24, sat);
      y  = bfit(w - fb, 24, sat);
      for (int k = 8; k > 1; k--) hy[id][k] = hy[id][k-1];
      hy[id][1] = y;
      y_out = bfit(brnd(y * gpost, 14, mode), 16, sat);
   endtask

   task automatic clear_model();
      for (int id = 0; id < 2; id++) begin
         for (int k = 0; k < 7; k++) hx[id][k] = 0;
         for (int k = 0; k < 3; k++) hw[id][k] = 0;
         for (int k = 0; k < 9; k++) hy[id][k] = 0;
         wr[id] = 0;
         rd[id] = 0;
         last_out[id] = 0;
      end
   endtask

   task automatic send(input bit v, input longint x);
      longint e;
      @(negedge clk);
      in_valid = v;
      in_data  = 16'(x);
      if (v) begin
         for (int id = 0; id < 2; id++) begin
            model_step(id, x, e);
            expq[id][wr[id]] = e;
            wr[id]++;
         end
         dcyc[wr[0]-1] = cyc;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send(1'b0, 16'sh5A5A ^ (i * 777));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      for (int id = 0; id < 2; id++) begin
         check("R1", longint'(ov[id]), 0);
         check("R1", longint'(od[id]), 0);
      end
      clear_model();
      rst_n = 1'b1;
   endtask

   // Output monitor: compares each result with the model; R2 latency, R9 hold
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int id = 0; id < 2; id++) begin
            if (ov[id]) begin
               if (rd[id] >= wr[id]) begin
                  check("R6 unexpected output", 1, 0);
               end else begin
                  check((id == 1) ? {cur_req, " R8"} : {cur_req, " R7"},
                        longint'(od[id]), expq[id][rd[id]]);
                  if (id == 0) check("R2", longint'(cyc - dcyc[rd[0]]), 5);
                  last_out[id] = longint'(od[id]);
                  rd[id]++;
               end
            end else begin
               check("R9", longint'(od[id]), last_out[id]);
            end
         end
      end
   end

   initial begin
      clear_model();
      repeat (3) @(negedge clk);
      do_reset();

      // R5: table with gaps; invalid rows carry garbage data (R6)
      cur_req = "R5";
      for (int i = 0; i < NV; i++) send(TAB_V[i], longint'(TAB_X[i]));
      idle(10);

      // R6: long run of garbage, then more samples continue the same state
      cur_req = "R6";
      idle(20);
      check("R6", longint'(wr[0] - rd[0]), 0);
      send(1'b1, 3000); send(1'b1, -3000); send(1'b1, 1500);
      send(1'b1, 0); send(1'b1, 0);
      idle(10);

      // R3 R10: impulse response of the look-ahead structure
      do_reset();
      cur_req = "R3 R10";
      send(1'b1, 1000);
      for (int i = 0; i < 39; i++) send(1'b1, 0);
      idle(10);
      check("R3", longint'(rd[0]), 40);

      // R4: large step, output overflows 16 bits
      do_reset();
      cur_req = "R4";
      for (int i = 0; i < 40; i++) send(1'b1, 30000);
      idle(10);
      check("R7 wrapped sign", longint'(last_out[0] < 0), 1);
      check("R8 clipped", last_out[1], 32767);

      // R1: reset with samples in flight drops them
      cur_req = "R1";
      send(1'b1, 500); send(1'b1, 600); send(1'b1, 700);
      do_reset();
      idle(10);
      check("R1", longint'(rd[0]), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL R2 watchdog: got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule